// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory read request issued together by all lanes of a warp and turns it into the fewest possible whole-line memory transactions. Each lane has an enable bit and a byte address for a 4-byte load. Memory is fetched in aligned 128-byte lines, so lanes that land in the same line can share a single transaction. The block sends exactly one transaction for each distinct line touched by an enabled lane. Each transaction carries the line number and a mask of the lanes it serves.

Transactions leave one per cycle on a valid/ready interface, and the block holds them steady under back-pressure. A flag marks the final transaction, and a one-cycle completion pulse follows it. With the pulse the block reports two counts: the bytes the lanes actually asked for and the bytes the issued transactions fetch. Comparing the two gives the memory bandwidth utilization of the access pattern.

Control is a three-state machine:
- **IDLE**: ready for a request. Accepting a request moves to ISSUE, or to DONE when no lane is enabled.
- **ISSUE**: issues one line per handshake. The handshake on the final line moves to DONE.
- **DONE**: raises the completion pulse for one cycle, then returns to IDLE.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0.
- R2: req_ready is high only in the idle state. It is low from the cycle after a request is taken (req_valid and req_ready both high at a clock edge) until the completion pulse has ended.
- R3: The number of transactions equals the number of distinct lines among enabled lanes. Each enabled lane appears in exactly one transaction mask (bit i of txn_mask is lane i), and a disabled lane appears in none.
- R4: Each transaction serves the lowest-numbered enabled lane not yet served. Its mask holds every unserved enabled lane whose line matches that lane's line, so lines leave in order of their lowest lane.
- R5: A lane's line number is its byte address shifted right by 7 (128-byte lines), and txn_line carries that number.
- R6: With all lanes enabled and an aligned base, a lane stride of 4 bytes gives 1 transaction, 32 bytes gives 8, and 128 bytes or more gives 32.
- R7: A unit-stride request whose base sits 64 bytes into a line gives 2 transactions: lanes 0..15 on the first line, then lanes 16..31 on the next.
- R8: While txn_valid is high and txn_ready is low, txn_valid, txn_line, txn_mask and txn_last hold their values into the next cycle.
- R9: A request with no enabled lane issues no transaction, and done is high in the cycle after the request is taken.
- R10: txn_last is high on the final transaction only. done is high for exactly one cycle, the cycle after the final handshake, and req_ready is high in the cycle after that.
- R11: While done is high, used_bytes equals 4 times the number of enabled lanes, and fetched_bytes equals 128 times the number of transactions issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_lane_en | input | LANES | Per-lane enable |
| req_addr | input | LANES*ADDR_W | Lane byte addresses; lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Line transaction present |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_line | output | ADDR_W-7 | Line number (byte address / 128) |
| txn_mask | output | LANES | Lanes served by this transaction |
| txn_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle completion pulse |
| used_bytes | output | 8 | Bytes requested by enabled lanes |
| fetched_bytes | output | 13 | Bytes fetched by the issued transactions |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses, 128-byte lines and 4-byte words. These values bring within reach the full range of transaction counts, from zero for an empty request to 32 for fully scattered lanes, as well as a line crossing at mid-warp. With 32 lanes, the stride-8 and stride-32 patterns land exactly on 8 and 32 lines. Random patterns confined to a small address window force many lanes to share lines in irregular groups. Back-pressure applied on every third cycle exercises the hold rule in the middle of a sequence.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_lead_pick.sv
// Finds the lowest-numbered set bit of the pending-lane vector.
module coal_lead_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0]         pend,
    output logic [$clog2(N)-1:0] lead_idx
);
    always_comb begin
        lead_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) lead_idx = ($clog2(N))'(i);
        end
    end
endmodule

// File: rtl/coal_line_match.sv
// Compares every pending lane's line against the leader's line.
module coal_line_match #(
    parameter int N  = 32,
    parameter int LW = 25
) (
    input  logic [N*LW-1:0]      lines,
    input  logic [N-1:0]         pend,
    input  logic [$clog2(N)-1:0] lead_idx,
    output logic [LW-1:0]        lead_line,
    output logic [N-1:0]         match
);
    assign lead_line = lines[lead_idx*LW +: LW];

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = pend[g] && (lines[g*LW +: LW] == lead_line);
    end
endmodule

// File: rtl/coal_popcount.sv
// Counts the set bits of a vector.
module coal_popcount #(
    parameter int N = 32,
    parameter int W = 6
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) count = count + W'(bits[i]);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int LINE_W  = ADDR_W - OFF_W,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int USED_W  = $clog2(LANES * WORD_BYTES + 1),
    localparam int FETCH_W = $clog2(LANES * LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_lane_en,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [LINE_W-1:0]       txn_line,
    output logic [LANES-1:0]        txn_mask,
    output logic                    txn_last,
    output logic                    done,
    output logic [USED_W-1:0]       used_bytes,
    output logic [FETCH_W-1:0]      fetched_bytes
);
    localparam int IDX_W = $clog2(LANES);

    coal_state_e state_q, state_d;

    logic [LANES*LINE_W-1:0] in_lines;
    logic [LANES*LINE_W-1:0] lines_q;
    logic [LANES*OFF_W-1:0]  in_offs;
    logic                    unused_offsets;
    logic [LANES-1:0]        pend_q, pend_d;
    logic [LANES-1:0]        match;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic [CNT_W-1:0]        active_cnt;
    logic [USED_W-1:0]       used_q, used_d;
    logic [IDX_W-1:0]        lead_idx;
    logic [LINE_W-1:0]       lead_line;
    logic                    load_req;

    // Split each lane address into line number and in-line offset.
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign in_lines[g*LINE_W +: LINE_W] = req_addr[g*ADDR_W + OFF_W +: LINE_W];
        assign in_offs[g*OFF_W +: OFF_W]    = req_addr[g*ADDR_W +: OFF_W];
    end
    assign unused_offsets = ^in_offs;

    coal_lead_pick #(.N(LANES)) u_pick (
        .pend     (pend_q),
        .lead_idx (lead_idx)
    );

    coal_line_match #(.N(LANES), .LW(LINE_W)) u_match (
        .lines     (lines_q),
        .pend      (pend_q),
        .lead_idx  (lead_idx),
        .lead_line (lead_line),
        .match     (match)
    );

    coal_popcount #(.N(LANES), .W(CNT_W)) u_pop (
        .bits  (req_lane_en),
        .count (active_cnt)
    );

    // State register and per-request bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
            used_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
            used_q  <= used_d;
        end
    end

    // Line numbers captured on acceptance.
    always_ff @(posedge clk) begin
        if (load_req) lines_q <= in_lines;
    end

    assign txn_last = ((pend_q & ~match) == '0);

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        cnt_d     = cnt_q;
        used_d    = used_q;
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        load_req  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load_req = 1'b1;
                    pend_d   = req_lane_en;
                    cnt_d    = '0;
                    used_d   = USED_W'(active_cnt) * USED_W'(WORD_BYTES);
                    state_d  = (req_lane_en == '0) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                txn_valid = 1'b1;
                if (txn_ready) begin
                    pend_d = pend_q & ~match;
                    cnt_d  = cnt_q + CNT_W'(1);
                    if (txn_last) state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign txn_mask      = txn_valid ? match : '0;
    assign txn_line      = lead_line;
    assign used_bytes    = used_q;
    assign fetched_bytes = FETCH_W'(cnt_q) * FETCH_W'(LINE_BYTES);
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int LINE_W  = ADDR_W - OFF_W,
    localparam int USED_W  = $clog2(LANES * WORD_BYTES + 1),
    localparam int FETCH_W = $clog2(LANES * LINE_BYTES + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [LANES-1:0]        req_lane_en,
    input logic [LANES*ADDR_W-1:0] req_addr,
    input logic                    txn_valid,
    input logic                    txn_ready,
    input logic [LINE_W-1:0]       txn_line,
    input logic [LANES-1:0]        txn_mask,
    input logic                    txn_last,
    input logic                    done,
    input logic [USED_W-1:0]       used_bytes,
    input logic [FETCH_W-1:0]      fetched_bytes
);
    logic [LANES-1:0] served_q, lanes_q;
    logic [31:0]      txn_cnt_q;
    logic             unused_addr;

    assign unused_addr = ^req_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served_q  <= '0;
            lanes_q   <= '0;
            txn_cnt_q <= '0;
        end else if (req_valid && req_ready) begin
            served_q  <= '0;
            lanes_q   <= req_lane_en;
            txn_cnt_q <= '0;
        end else if (txn_valid && txn_ready) begin
            served_q  <= served_q | txn_mask;
            txn_cnt_q <= txn_cnt_q + 32'd1;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done) |-> !req_ready); // R2

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0)); // R4

    AST_MASK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (((txn_mask & served_q) == '0) && ((txn_mask & ~lanes_q) == '0))); // R3

    AST_ALL_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (served_q == lanes_q)); // R3

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_mask) && $stable(txn_last))); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_last) |=> done); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R10

    AST_USED_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (used_bytes == USED_W'($countones(lanes_q) * WORD_BYTES))); // R11

    AST_FETCHED_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fetched_bytes == FETCH_W'(txn_cnt_q * LINE_BYTES))); // R11
endmodule

bind warp_coalescer warp_coalescer_chk #(
    .LANES      (LANES),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES)
) u_chk (.*);

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int LW    = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LANES-1:0]  req_lane_en = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic              txn_valid;
    logic              txn_ready = 1'b0;
    logic [LW-1:0]     txn_line;
    logic [LANES-1:0]  txn_mask;
    logic              txn_last;
    logic              done;
    logic [7:0]        used_bytes;
    logic [12:0]       fetched_bytes;

    always #5 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_lane_en(req_lane_en), .req_addr(req_addr),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_line(txn_line), .txn_mask(txn_mask), .txn_last(txn_last),
        .done(done), .used_bytes(used_bytes), .fetched_bytes(fetched_bytes)
    );

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;
    logic [31:0] addr_a [LANES];
    logic [LW-1:0]    exp_line [LANES];
    logic [LANES-1:0] exp_mask [LANES];
    int          exp_n;
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // Reference grouping taken from the requirement text (R3, R4, R5).
    task automatic build_expect(input logic [LANES-1:0] en);
        logic [LANES-1:0] pend;
        pend  = en;
        exp_n = 0;
        while (pend != '0) begin
            int lead = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            exp_line[exp_n] = addr_a[lead][31:7];
            exp_mask[exp_n] = '0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && addr_a[i][31:7] == addr_a[lead][31:7]) exp_mask[exp_n][i] = 1'b1;
            pend = pend & ~exp_mask[exp_n];
            exp_n++;
        end
    endtask

    task automatic run_req(input string tag, input logic [LANES-1:0] en,
                           input bit stall, input int want_n);
        int n = 0;
        int cyc = 0;
        bit got_done = 1'b0;
        bit holding = 1'b0;
        logic [LW-1:0] h_line;
        logic [LANES-1:0] h_mask;
        logic h_last;
        build_expect(en);
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid   = 1'b1;
        req_lane_en = en;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = addr_a[i];
        @(negedge clk);
        req_valid = 1'b0;
        while (!got_done && cyc < 400) begin
            txn_ready = 1'b0;
            if (done) begin
                got_done = 1'b1;
            end else begin
                check(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
                if (txn_valid) begin
                    bit rdy;
                    if (holding) begin
                        check(txn_line == h_line && txn_mask == h_mask && txn_last == h_last,
                              "R8", "held transaction", txn_mask, h_mask);
                    end
                    rdy = stall ? ((cyc % 3) != 0) : 1'b1;
                    if (rdy) begin
                        if (n < exp_n) begin
                            check(txn_line == exp_line[n], "R5", "line", txn_line, exp_line[n]);
                            check(txn_mask == exp_mask[n], "R4", "mask", txn_mask, exp_mask[n]);
                            check(txn_last == (n == exp_n - 1), "R10", "last flag", txn_last, (n == exp_n - 1));
                        end
                        n++;
                        holding = 1'b0;
                    end else begin
                        holding = 1'b1;
                        h_line = txn_line;
                        h_mask = txn_mask;
                        h_last = txn_last;
                    end
                    txn_ready = rdy;
                end
                @(negedge clk);
                cyc++;
            end
        end
        txn_ready = 1'b0;
        check(got_done, "R10", "done reached", got_done, 1);
        check(n == exp_n, "R3", "transaction count vs distinct lines", n, exp_n);
        if (want_n >= 0) check(n == want_n, tag, "transaction count", n, want_n);
        check(used_bytes == 8'($countones(en) * 4), "R11", "used bytes", used_bytes, $countones(en) * 4);
        check(fetched_bytes == 13'(exp_n * 128), "R11", "fetched bytes", fetched_bytes, exp_n * 128);
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R10", "done one cycle then idle", done, 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "req_ready at reset", req_ready, 1);
        check(txn_valid == 1'b0, "R1", "txn_valid at reset", txn_valid, 0);
        check(done == 1'b0, "R1", "done at reset", done, 0);
    endtask

    task automatic t_stride(input int bytes, input int want);
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0001_0000 + 32'(i * bytes);
        run_req("R6", '1, 1'b0, want);
    endtask

    task automatic t_misaligned();
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0002_0040 + 32'(i * 4);
        run_req("R7", '1, 1'b0, 2);
    endtask

    task automatic t_broadcast();
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0003_0104;
        run_req("R3", '1, 1'b1, 1);
    endtask

    task automatic t_partial();
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0004_0000 + 32'(i * 32);
        run_req("R3", 32'h8421_0F0F, 1'b0, -1);
    endtask

    task automatic t_empty();
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'(i * 128);
        run_req("R9", '0, 1'b0, 0);
    endtask

    task automatic t_random(input int reps);
        for (int r = 0; r < reps; r++) begin
            logic [31:0] en;
            for (int i = 0; i < LANES; i++)
                addr_a[i] = 32'h0005_0000 + ((next_rand() >> 8) & 32'h0000_07FC);
            en = next_rand() | next_rand();
            run_req("R4", en, r[0], -1);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #12;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_stride(4, 1);
        t_stride(32, 8);
        t_stride(128, 32);
        t_stride(4096, 32);
        t_misaligned();
        t_broadcast();
        t_partial();
        t_empty();
        t_stride(32, 8);
        t_random(12);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule